// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupt Detection

This block controls 64 general-purpose pins, split into two banks of 32. Each pin has four controls: a direction bit, a select bit that hands the pin either to the GPIO logic or to an alternate on-chip function, an output data bit, and a read-back of its input. The input read-back passes through a two-flop synchroniser. Pin n sits in bank n/32 at bit n%32. A small register bus reads and writes the controls. A write takes effect on the next clock edge. Read data appears on the cycle after the read strobe.

Pins 0 to 15 also have an interrupt detector. Each detector has three configuration bits: an edge flag, a high flag and a low flag. Together they select level-low, level-high, rising, falling or both-edge detection, or no detection at all. A detected event sets a sticky pending flag, whether or not the pin is enabled. Software clears a flag by setting the pin's bit in the clear register and then writing it back to zero. The interrupt line is raised when any pin is both pending and enabled.

Top module: `gpioIrqCtrl`

## Requirements
- R1: After reset, every control register reads 0: direction, select, output data, edge, high, low, enable, clear and pending. With pins held low, irqOut, pinOe and pinOut are 0.
- R2: The register word addresses are as follows:
  - 0: direction, bank 0. 1: direction, bank 1.
  - 2: select, bank 0. 3: select, bank 1.
  - 4: output data, bank 0. 5: output data, bank 1.
  - 6: input, bank 0. 7: input, bank 1.
  - 8: edge. 9: high. 10: low. 11: enable. 12: clear. 13: pending.
  
  Addresses 6, 7 and 13 are read-only, and writes to them, or to addresses 14 and 15, change nothing. The interrupt registers use bits 15:0, and their upper bits read as zero. Read data is valid the cycle after busRd.
- R3: When a pin's select bit is 0, pinOe equals its direction bit (1 = output) and pinOut equals its output data bit.
- R4: When a pin's select bit is 1, pinOut equals altOut and pinOe equals altOe for that pin.
- R5: The input registers return each pin's level after a two-flop synchroniser, whatever its direction. A read issued at least two edges after a pin change returns the new value.
- R6: With edge=0, the pin sets its pending flag while its synchronised level is low if low=1, and while it is high if high=1.
- R7: With edge=1, the pin sets its pending flag on a synchronised 0-to-1 transition if high=1, and on a 1-to-0 transition if low=1. Setting both bits detects both edges.
- R8: A pin whose high and low bits are both 0 never sets its pending flag. Pins 16 to 63 have no pending flag.
- R9: Pending flags stay set until cleared, and they set whether or not the pin is enabled.
- R10: While a pin's clear bit is 1, its pending flag is 0. Writing 0xFFFF and then 0 to the clear register clears all flags. In level mode, the flag sets again after release if the level still holds.
- R11: irqOut is 1 exactly when some pin has both its pending bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after busRd |
| pinIn | input | 64 | Pin input levels (asynchronous) |
| altOut | input | 64 | Alternate-function output data |
| altOe | input | 64 | Alternate-function output enable |
| pinOut | output | 64 | Pad output data |
| pinOe | output | 64 | Pad output enable |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A corrupted pending flag shows up in one of two places. If its pin is enabled, it appears on irqOut in the same cycle. If not, it appears on the next read of address 13. A broken synchroniser shows up as input read-back or edge detection that is one cycle early or late. A faulty clear shows up as a pending bit that survives while its clear bit is held. A bench model follows the pins cycle by cycle, so each of these faults is reported on the first cycle it can be seen.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int IRQ_W     = 16;
  localparam int ADDR_W    = 4;
  localparam int NUM_REGS  = 14;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR0 = 4'd0, RA_DIR1 = 4'd1, RA_SEL0 = 4'd2, RA_SEL1 = 4'd3,
    RA_OUT0 = 4'd4, RA_OUT1 = 4'd5, RA_IN0  = 4'd6, RA_IN1  = 4'd7,
    RA_EDGE = 4'd8, RA_HIGH = 4'd9, RA_LOW  = 4'd10, RA_EN  = 4'd11,
    RA_CLR  = 4'd12, RA_PEND = 4'd13
  } regAddr_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrHit;
    logic                rdHit;
    logic [ADDR_W-1:0]   rdIdx;
  } busStrobe_t;
endpackage

// File: rtl/gpio_busDecode.sv
module gpio_busDecode
  import gpio_pkg::*;
(
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  always_comb begin
    strobe.wrHit = '0;
    if (busWr && (int'(busAddr) < NUM_REGS))
      strobe.wrHit = NUM_REGS'(1) << busAddr;
    strobe.wrHit[RA_IN0]  = 1'b0;
    strobe.wrHit[RA_IN1]  = 1'b0;
    strobe.wrHit[RA_PEND] = 1'b0;
    strobe.rdHit = busRd;
    strobe.rdIdx = busAddr;
  end
endmodule

// File: rtl/gpio_pinPath.sv
module gpio_pinPath
  import gpio_pkg::*;
#(
  parameter int BankW    = BANK_W,
  parameter int NumBanks = NUM_BANKS,
  parameter int IrqW     = IRQ_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busStrobe_t                strobe,
  input  logic [BankW-1:0]          busWdata,
  output logic [BankW-1:0]          busRdata,
  input  logic [NumBanks*BankW-1:0] pinIn,
  input  logic [NumBanks*BankW-1:0] altOut,
  input  logic [NumBanks*BankW-1:0] altOe,
  output logic [NumBanks*BankW-1:0] pinOut,
  output logic [NumBanks*BankW-1:0] pinOe,
  output logic                      irqOut
);
  localparam int Pins = NumBanks * BankW;

  logic [NumBanks-1:0][BankW-1:0] dirQ, selQ, outQ, syncA, syncB, prevQ;
  logic [IrqW-1:0] edgeQ, highQ, lowQ, enQ, clrQ, pendQ, hitV;
  logic [Pins-1:0] dirF, selF, outF, curF, oldF;

  assign dirF = dirQ;
  assign selF = selQ;
  assign outF = outQ;
  assign curF = syncB;
  assign oldF = prevQ;

  // per-bank control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= '0;
      selQ <= '0;
      outQ <= '0;
    end else begin
      for (int b = 0; b < NumBanks; b++) begin
        if (strobe.wrHit[int'(RA_DIR0) + b]) dirQ[b] <= busWdata;
        if (strobe.wrHit[int'(RA_SEL0) + b]) selQ[b] <= busWdata;
        if (strobe.wrHit[int'(RA_OUT0) + b]) outQ[b] <= busWdata;
      end
    end
  end

  // two-flop synchroniser plus history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  // pad mux
  assign pinOut = (selF & altOut) | (~selF & outF);
  assign pinOe  = (selF & altOe)  | (~selF & dirF);

  // per-pin trigger detectors
  for (genvar i = 0; i < IrqW; i++) begin : gDet
    logic riseV, fallV;
    assign riseV   = curF[i] & ~oldF[i];
    assign fallV   = ~curF[i] & oldF[i];
    assign hitV[i] = edgeQ[i] ? ((highQ[i] & riseV) | (lowQ[i] & fallV))
                              : ((highQ[i] & curF[i]) | (lowQ[i] & ~curF[i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeQ <= '0; highQ <= '0; lowQ <= '0;
      enQ   <= '0; clrQ  <= '0; pendQ <= '0;
    end else begin
      if (strobe.wrHit[RA_EDGE]) edgeQ <= busWdata[IrqW-1:0];
      if (strobe.wrHit[RA_HIGH]) highQ <= busWdata[IrqW-1:0];
      if (strobe.wrHit[RA_LOW])  lowQ  <= busWdata[IrqW-1:0];
      if (strobe.wrHit[RA_EN])   enQ   <= busWdata[IrqW-1:0];
      if (strobe.wrHit[RA_CLR])  clrQ  <= busWdata[IrqW-1:0];
      pendQ <= ~clrQ & (pendQ | hitV);
    end
  end

  assign irqOut = |(pendQ & enQ);

  // registered read-back
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobe.rdHit) begin
      case (strobe.rdIdx)
        RA_DIR0: busRdata <= dirQ[0];
        RA_DIR1: busRdata <= dirQ[NumBanks-1];
        RA_SEL0: busRdata <= selQ[0];
        RA_SEL1: busRdata <= selQ[NumBanks-1];
        RA_OUT0: busRdata <= outQ[0];
        RA_OUT1: busRdata <= outQ[NumBanks-1];
        RA_IN0:  busRdata <= syncB[0];
        RA_IN1:  busRdata <= syncB[NumBanks-1];
        RA_EDGE: busRdata <= BankW'(edgeQ);
        RA_HIGH: busRdata <= BankW'(highQ);
        RA_LOW:  busRdata <= BankW'(lowQ);
        RA_EN:   busRdata <= BankW'(enQ);
        RA_CLR:  busRdata <= BankW'(clrQ);
        RA_PEND: busRdata <= BankW'(pendQ);
        default: busRdata <= '0;
      endcase
    end
  end

  // R1: registers come out of reset at zero
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |=> (dirQ == '0 && selQ == '0 && outQ == '0 && edgeQ == '0 &&
               highQ == '0 && lowQ == '0 && enQ == '0 && clrQ == '0 && pendQ == '0));

  // R10: a held clear bit forces its flag low on the following cycle
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(clrQ)) == '0));

  // R9: an uncleared flag never drops
  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pendQ) & ~$past(clrQ) & ~pendQ) == '0));

  // R8: a pin with high and low both zero never raises its flag
  assert_quiet_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(highQ | lowQ)) == '0));

  // R11: the request line needs an enabled, pending pin
  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enQ != '0 && pendQ != '0));
endmodule

// File: rtl/gpioIrqCtrl.sv
module gpioIrqCtrl
  import gpio_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busRd,
  input  logic                        busWr,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [BANK_W-1:0]           busWdata,
  output logic [BANK_W-1:0]           busRdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pinIn,
  input  logic [NUM_BANKS*BANK_W-1:0] altOut,
  input  logic [NUM_BANKS*BANK_W-1:0] altOe,
  output logic [NUM_BANKS*BANK_W-1:0] pinOut,
  output logic [NUM_BANKS*BANK_W-1:0] pinOe,
  output logic                        irqOut
);
  busStrobe_t strobe;

  gpio_busDecode uDecode (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_pinPath #(
    .BankW    (BANK_W),
    .NumBanks (NUM_BANKS),
    .IrqW     (IRQ_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .altOut   (altOut),
    .altOe    (altOe),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/gpioIrqCtrl_test.sv
`timescale 1ns/1ps
module gpioIrqCtrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] pinIn = '0, altOut = '0, altOe = '0;
  logic [63:0] pinOut, pinOe;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;

  // bench reference state
  logic [63:0] mDir = '0, mSel = '0, mOut = '0, mS1 = '0, mS2 = '0, mPrev = '0;
  logic [15:0] mEdge = '0, mHigh = '0, mLow = '0, mEn = '0, mClr = '0, mPend = '0;
  string rdTag = "R2";

  always #4 clk = ~clk;

  gpioIrqCtrl uut (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .altOut(altOut),
    .altOe(altOe), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(logic [3:0] a);
    case (a)
      4'd0: return mDir[31:0];   4'd1: return mDir[63:32];
      4'd2: return mSel[31:0];   4'd3: return mSel[63:32];
      4'd4: return mOut[31:0];   4'd5: return mOut[63:32];
      4'd6: return mS2[31:0];    4'd7: return mS2[63:32];
      4'd8: return {16'h0, mEdge};  4'd9:  return {16'h0, mHigh};
      4'd10: return {16'h0, mLow};  4'd11: return {16'h0, mEn};
      4'd12: return {16'h0, mClr};  4'd13: return {16'h0, mPend};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] trigHits();
    logic [15:0] h;
    for (int i = 0; i < 16; i++) begin
      if (mEdge[i])
        h[i] = (mHigh[i] & mS2[i] & ~mPrev[i]) | (mLow[i] & ~mS2[i] & mPrev[i]);
      else
        h[i] = (mHigh[i] & mS2[i]) | (mLow[i] & ~mS2[i]);
    end
    return h;
  endfunction

  task automatic applyWrite(logic [3:0] a, logic [31:0] d);
    case (a)
      4'd0: mDir[31:0] = d;  4'd1: mDir[63:32] = d;
      4'd2: mSel[31:0] = d;  4'd3: mSel[63:32] = d;
      4'd4: mOut[31:0] = d;  4'd5: mOut[63:32] = d;
      4'd8: mEdge = d[15:0]; 4'd9: mHigh = d[15:0];
      4'd10: mLow = d[15:0]; 4'd11: mEn = d[15:0];
      4'd12: mClr = d[15:0];
      default: ;
    endcase
  endtask

  // one clock: model step, edge, then output checks at the falling edge
  task automatic cyc();
    logic [15:0] nPend;
    logic [31:0] rdExp;
    logic        didRd;
    nPend = ~mClr & (mPend | trigHits());
    rdExp = expRead(busAddr);
    didRd = busRd;
    @(posedge clk);
    mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    mPend = nPend;
    if (busWr) applyWrite(busAddr, busWdata);
    @(negedge clk);
    chk("R11 irqOut", {63'h0, irqOut}, {63'h0, |(mPend & mEn)});
    chk("R3 R4 pinOe", pinOe, (mSel & altOe) | (~mSel & mDir));
    chk("R3 R4 pinOut", pinOut, (mSel & altOut) | (~mSel & mOut));
    if (didRd) chk(rdTag, {32'h0, busRdata}, {32'h0, rdExp});
    busRd = 1'b0;
    busWr = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    cyc();
  endtask

  task automatic rd(logic [3:0] a, string tag);
    rdTag = tag;
    busRd = 1'b1; busAddr = a;
    cyc();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 irqOut in reset", {63'h0, irqOut}, 64'h0);
    chk("R1 pinOe in reset", pinOe, 64'h0);
    chk("R1 pinOut in reset", pinOut, 64'h0);
    rstN = 1'b1;
    for (int a = 0; a < 14; a++) rd(4'(a), "R1 reset readback");

    // R2: bank mapping, read-only and unused addresses
    wr(4'd1, 32'h0000_0100);
    chk("R2 pin 40 oe", {63'h0, pinOe[40]}, 64'h1);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd13, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd13, "R2 pending not writable");
    wr(4'd8, 32'hFFFF_0000);
    rd(4'd8, "R2 upper bits zero");
    wr(4'd8, 32'h0);

    // R4: alternate function routing
    altOut = 64'hA5A5_0000_0000_5A5A; altOe = 64'hFFFF_0000_0000_FFFF;
    wr(4'd2, 32'h0000_FFFF);
    wr(4'd2, 32'h0);

    // R5: input read-back on pins set as outputs
    wr(4'd0, 32'hFFFF_FFFF);
    pinIn = 64'h1234_5678_0000_0000 | 64'h0000_0000_00F0_0000;
    idle(2);
    rd(4'd6, "R5 input bank0");
    rd(4'd7, "R5 input bank1");

    // R6: level-low on pin 3, disabled first (R9), then enabled (R11)
    wr(4'd10, 32'h0000_0008);
    idle(2);
    rd(4'd13, "R6 R9 level low pending");
    chk("R9 disabled no irq", {63'h0, irqOut}, 64'h0);
    wr(4'd11, 32'h0000_0008);
    chk("R11 enabled irq", {63'h0, irqOut}, 64'h1);

    // R10: clear all held, then release with level still low
    wr(4'd12, 32'h0000_FFFF);
    idle(1);
    rd(4'd13, "R10 held clear");
    chk("R10 cleared bit3", {63'h0, busRdata[3]}, 64'h0);
    wr(4'd12, 32'h0);
    idle(1);
    rd(4'd13, "R10 level re-pends");
    chk("R10 re-set bit3", {63'h0, busRdata[3]}, 64'h1);
    wr(4'd10, 32'h0);
    wr(4'd12, 32'h0000_0008); wr(4'd12, 32'h0);

    // R7: rising on pin 5, falling on pin 6, both on pin 7
    wr(4'd8, 32'h0000_00E0); wr(4'd9, 32'h0000_00A0); wr(4'd10, 32'h0000_00C0);
    pinIn[7:5] = 3'b111; idle(4);
    rd(4'd13, "R7 rising and both");
    pinIn[7:5] = 3'b000; idle(4);
    rd(4'd13, "R7 falling and both");
    wr(4'd12, 32'h0000_FFFF); wr(4'd12, 32'h0);

    // R8: unconfigured and high pins toggle without pending
    wr(4'd8, 32'h0); wr(4'd9, 32'h0); wr(4'd10, 32'h0);
    pinIn[20] = 1'b1; pinIn[9] = 1'b1; idle(3);
    pinIn[20] = 1'b0; pinIn[9] = 1'b0; idle(3);
    rd(4'd13, "R8 no pending");

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      case ($urandom % 5)
        0: begin
          logic [3:0]  a;
          logic [31:0] d;
          a = 4'($urandom % 16);
          d = $urandom;
          if (a == 4'd12 && ($urandom % 4) != 0) d = 32'h0;
          wr(a, d);
        end
        1: begin
          pinIn = {$urandom, $urandom};
          cyc();
        end
        2: begin
          pinIn[15:0] = pinIn[15:0] ^ 16'(1 << ($urandom % 16));
          cyc();
        end
        3: rd(4'($urandom % 16), "R2 R5 R9 random readback");
        default: begin
          altOut = {$urandom, $urandom};
          altOe  = {$urandom, $urandom};
          cyc();
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule